// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Wrapped Line Fill

This block is a read-only, direct-mapped cache for an instruction fetch path. Addresses and data words are 32 bits wide, and bytes are big-endian inside a word. The cache passes each word through unchanged, so byte 0 sits in bits 31:24. A line holds four words. The line index comes from the address bits just above the 16-byte line offset. A stored tag, compared with the upper address bits, decides whether the access hits. The total capacity is the parameter `CACHE_KB`. Its legal values are 2, 4, 8, 16, 32 and 64, giving `CACHE_KB*64` lines.

On the processor side there is a valid/ready lookup port and a response strobe. On a hit, the word comes back one cycle after the request is accepted, and a new request can be accepted in that same cycle. On a miss, the cache asks the memory side for the line, starting at the missed word. The memory returns four words in wrapping order: the missed word first, then the ones after it, wrapping modulo four. The first word is forwarded to the processor in the same cycle it arrives. The tag and valid bit are committed only when the fourth word lands. No new lookup is accepted until that happens.

The controller has four states:
- `S_IDLE` accepts a request and moves to `S_LOOKUP`.
- `S_LOOKUP` compares the tag.
  - On a hit, it answers. It stays in `S_LOOKUP` if another request is accepted, and otherwise returns to `S_IDLE`.
  - On a miss, it moves to `S_MISS_REQ`.
- `S_MISS_REQ` holds the memory request until it is accepted, then moves to `S_FILL`.
- `S_FILL` writes one word per memory beat and returns to `S_IDLE` after the fourth beat.

Top module: `icache_cwf`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every line is invalid, so the first access to any line misses.
- R2: A hit raises `rsp_valid` with the stored word in the cycle after the request is accepted, and `req_ready` stays high in that cycle so hits can follow back to back.
- R3: A miss raises `mem_req_valid` two cycles after acceptance. `mem_req_addr` carries the missed word's address with bits 1:0 zero. The request and its address hold steady until `mem_req_ready` is seen.
- R4: The memory delivers the line in the order c, c+1, c+2, c+3 (mod 4), where c is bits 3:2 of the missed address. Each beat is stored in its own word slot, so after the fill all four words of the line hit with the memory's data.
- R5: The first fill beat drives `rsp_valid` with `mem_rsp_data` in the same cycle. Later beats of the fill produce no response.
- R6: `req_ready` is 0 from the miss decision until the cycle after the fourth fill beat. Apart from R2 and R5, `rsp_valid` is never raised.
- R7: Two addresses with equal bits [IDX_W+3:4] but different upper bits share one line. Filling one evicts the other, so the evicted address misses again.
- R8: The line count is `CACHE_KB*64`. At the default of 2 kB, addresses 0x800 apart conflict, while addresses 0x400 apart occupy different lines and both stay resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request accepted this cycle when valid |
| req_addr | input | 32 | Byte address of the fetch |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_data | output | 32 | Response word |
| mem_req_valid | output | 1 | Line fill request to memory |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_req_addr | output | 32 | Address of the critical word (bits 1:0 zero) |
| mem_rsp_valid | input | 1 | One fill beat present |
| mem_rsp_data | input | 32 | Fill beat data, in wrapping order |

## Verification
Several internal faults show up at the ports almost at once:
- A valid bit set too early, or a tag left stale, turns a predicted miss into a response in the cycle right after acceptance.
- A lost line turns a predicted hit into a silent cycle in that same cycle.
- A wrong wrap order or word slot stays hidden until the line is read back. It then appears as wrong data on the first hit to the misplaced word.
- A fault in the stall logic shows up as `req_ready` during the fill, or as a second response during a fill.

The bench compares every cycle's response strobe and data against its own model of resident lines. That model is built from the fill beats it issued itself.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int WORDS_PER_LINE = 4;
    localparam int WSEL_W         = 2;
    localparam int LINE_OFS_W     = 4;
    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOKUP,
        S_MISS_REQ,
        S_FILL
    } ic_state_e;

    function automatic int lines_for_kb(int kb);
        return kb * 1024 / (WORDS_PER_LINE * 4);
    endfunction
endpackage

// File: rtl/icache_store.sv
module icache_store
    import icache_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int IDX_W     = 7,
    parameter int TAG_W     = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [WSEL_W-1:0]    rd_wsel,
    output logic [TAG_W-1:0]     rd_tag,
    output logic                 rd_vld,
    output logic [DATA_W-1:0]    rd_word,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WSEL_W-1:0]    wr_wsel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 tag_we,
    input  logic [TAG_W-1:0]     tag_val
);
    localparam int NUM_WORDS = NUM_LINES * WORDS_PER_LINE;

    logic [NUM_LINES-1:0] vld;
    logic [TAG_W-1:0]     tmem [NUM_LINES];
    logic [DATA_W-1:0]    dmem [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (tag_we) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (tag_we) tmem[wr_idx] <= tag_val;
        if (wr_en)  dmem[{wr_idx, wr_wsel}] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
        end else if (rd_en) begin
            rd_vld <= vld[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag  <= tmem[rd_idx];
            rd_word <= dmem[{rd_idx, rd_wsel}];
        end
    end

    // R4: a committed line is valid and carries the written tag on the next cycle
    p_tag_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |=> vld[$past(wr_idx)] && (tmem[$past(wr_idx)] == $past(tag_val)));
endmodule

// File: rtl/icache_fill_seq.sv
module icache_fill_seq
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WSEL_W-1:0] crit,
    input  logic              beat,
    output logic [WSEL_W-1:0] slot,
    output logic              first,
    output logic              last
);
    logic [WSEL_W-1:0] cnt_q;
    logic [WSEL_W-1:0] crit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            crit_q <= '0;
        end else if (start) begin
            cnt_q  <= '0;
            crit_q <= crit;
        end else if (beat) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign slot  = crit_q + cnt_q;
    assign first = (cnt_q == '0);
    assign last  = (cnt_q == WSEL_W'(WORDS_PER_LINE - 1));

    // R4: consecutive beats land in consecutive slots, wrapping modulo four
    p_wrap_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !start && !last) |=> (slot == $past(slot) + 1'b1));
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic hit,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic fill_last,
    output logic req_ready,
    output logic accept,
    output logic hit_rsp,
    output logic fill_start,
    output logic mem_req_valid,
    output logic beat,
    output logic fill_active,
    output logic tag_we
);
    ic_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d          = st_q;
        req_ready     = 1'b0;
        hit_rsp       = 1'b0;
        fill_start    = 1'b0;
        mem_req_valid = 1'b0;
        beat          = 1'b0;
        fill_active   = 1'b0;
        tag_we        = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) st_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (hit) begin
                    hit_rsp   = 1'b1;
                    req_ready = 1'b1;
                    st_d      = req_valid ? S_LOOKUP : S_IDLE;
                end else begin
                    fill_start = 1'b1;
                    st_d       = S_MISS_REQ;
                end
            end
            S_MISS_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_d = S_FILL;
            end
            S_FILL: begin
                fill_active = 1'b1;
                beat        = mem_rsp_valid;
                if (mem_rsp_valid && fill_last) begin
                    tag_we = 1'b1;
                    st_d   = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign accept = req_valid && req_ready;

    // R2: an accepted request is looked up in the following cycle
    p_accept_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q == S_LOOKUP));
    // R6: the last fill beat releases the stall on the next cycle
    p_fill_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && fill_last) |=> (st_q == S_IDLE));
endmodule

// File: rtl/icache_cwf.sv
module icache_cwf
    import icache_pkg::*;
#(
    parameter int CACHE_KB = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    localparam int NUM_LINES = lines_for_kb(CACHE_KB);
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int TAG_W     = ADDR_W - IDX_W - LINE_OFS_W;

    logic [ADDR_W-1:2]  q_word;
    logic [TAG_W-1:0]   rd_tag;
    logic               rd_vld;
    logic [DATA_W-1:0]  rd_word;
    logic               hit, accept, hit_rsp, fill_start, beat, fill_active, tag_we;
    logic [WSEL_W-1:0]  slot;
    logic               seq_first, seq_last;
    logic               unused_byte;

    assign unused_byte = ^req_addr[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)      q_word <= '0;
        else if (accept) q_word <= req_addr[ADDR_W-1:2];
    end

    assign hit = rd_vld && (rd_tag == q_word[ADDR_W-1:IDX_W+LINE_OFS_W]);

    icache_ctrl u_ctrl (
        .clk, .rst_n, .req_valid, .hit, .mem_req_ready, .mem_rsp_valid,
        .fill_last(seq_last), .req_ready, .accept, .hit_rsp, .fill_start,
        .mem_req_valid, .beat, .fill_active, .tag_we
    );

    icache_fill_seq u_seq (
        .clk, .rst_n, .start(fill_start), .crit(q_word[3:2]), .beat,
        .slot, .first(seq_first), .last(seq_last)
    );

    icache_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk, .rst_n,
        .rd_en(accept), .rd_idx(req_addr[IDX_W+LINE_OFS_W-1:LINE_OFS_W]),
        .rd_wsel(req_addr[3:2]), .rd_tag, .rd_vld, .rd_word,
        .wr_en(beat), .wr_idx(q_word[IDX_W+LINE_OFS_W-1:LINE_OFS_W]),
        .wr_wsel(slot), .wr_data(mem_rsp_data),
        .tag_we, .tag_val(q_word[ADDR_W-1:IDX_W+LINE_OFS_W])
    );

    assign mem_req_addr = {q_word, 2'b00};
    assign rsp_valid    = hit_rsp || (beat && seq_first);
    assign rsp_data     = hit_rsp ? rd_word : mem_rsp_data;

    // R3: an unanswered fill request keeps its address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R6: no lookup accepted while a fill request is outstanding
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R5: during a fill only the first beat is forwarded
    p_first_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fill_active) |-> seq_first);
endmodule

// File: tb/sim_icache_cwf.sv
module sim_icache_cwf;
    localparam int CLK_NS   = 10;
    localparam int CACHE_KB = 2;
    localparam int IDX_W    = $clog2(CACHE_KB * 64);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    icache_cwf #(.CACHE_KB(CACHE_KB)) u0 (.*);

    always #(CLK_NS / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_data [int];
    string       exp_tag  [int];
    bit          mdl_vld  [int];
    logic [31:0] mdl_tag  [int];
    bit          miss_pending = 0;
    logic [31:0] miss_addr = '0;
    bit          mon_on = 0;
    bit          done = 0;
    int          fill_no = 0;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return (a[31:2] * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (exp_data.exists(cyc)) begin
                check(rsp_valid === 1'b1 && rsp_data === exp_data[cyc], exp_tag[cyc],
                      "response", rsp_data, exp_data[cyc]);
                exp_data.delete(cyc);
                exp_tag.delete(cyc);
            end else begin
                check(rsp_valid === 1'b0, "R6", "spurious response", {31'b0, rsp_valid}, 32'h0);
            end
            if (mem_req_valid)
                check(req_ready === 1'b0, "R6", "ready during miss", {31'b0, req_ready}, 32'h0);
        end
    end

    task automatic rd(logic [31:0] addr, string req);
        int n;
        logic [IDX_W-1:0] idx;
        logic [31:0] tg;
        req_valid = 1'b1;
        req_addr  = addr;
        do @(negedge clk); while (req_ready !== 1'b1);
        @(posedge clk); #1;
        n   = cyc;
        idx = addr[IDX_W+3:4];
        tg  = addr >> (IDX_W + 4);
        if (mdl_vld.exists(int'(idx)) && mdl_tag[int'(idx)] == tg) begin
            exp_data[n] = mem_word(addr);
            exp_tag[n]  = req;
        end else begin
            miss_pending = 1;
            miss_addr    = {addr[31:2], 2'b00};
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(int k);
        repeat (k) begin @(posedge clk); #1; end
    endtask

    // Memory responder: wrapped four-beat fill
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && mem_req_valid) begin
                logic [31:0] a;
                logic [IDX_W-1:0] idx;
                check(miss_pending == 1, "R3", "request without miss", mem_req_addr, miss_addr);
                check(mem_req_addr === miss_addr, "R3", "request address", mem_req_addr, miss_addr);
                repeat (fill_no % 3) begin
                    @(posedge clk); #1;
                    check(mem_req_valid === 1'b1 && mem_req_addr === miss_addr, "R3",
                          "request held", mem_req_addr, miss_addr);
                end
                mem_req_ready = 1'b1;
                @(posedge clk); #1;
                mem_req_ready = 1'b0;
                miss_pending  = 0;
                @(posedge clk); #1;
                for (int k = 0; k < 4; k++) begin
                    logic [1:0] w;
                    w = miss_addr[3:2] + 2'(k);
                    a = {miss_addr[31:4], w, 2'b00};
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(a);
                    if (k == 0) begin
                        exp_data[cyc] = mem_rsp_data;
                        exp_tag[cyc]  = "R5";
                    end
                    if (k == 3) begin
                        idx = miss_addr[IDX_W+3:4];
                        mdl_vld[int'(idx)] = 1;
                        mdl_tag[int'(idx)] = miss_addr >> (IDX_W + 4);
                    end
                    @(posedge clk); #1;
                    mem_rsp_valid = 1'b0;
                    mem_rsp_data  = '0;
                    if (fill_no[0] && k < 3) begin @(posedge clk); #1; end
                end
                fill_no++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R6", "watchdog expired", 32'h0, 32'h1);
            summary();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready === 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'h1);
        check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        check(mem_req_valid === 1'b0, "R1", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'h0);
        mon_on = 1;
        @(posedge clk); #1;

        // R1 first access misses; R4 order 0,1,2,3
        rd(32'h0000_0100, "R1");
        for (int i = 1; i < 4; i++) rd(32'h0000_0100 + 32'(4 * i), "R4");
        // R4 critical word 2: order 2,3,0,1
        rd(32'h0000_0208, "R4");
        for (int i = 0; i < 4; i++) rd(32'h0000_0200 + 32'(4 * i), "R4");
        // R4 critical word 3
        rd(32'h0000_030C, "R4");
        for (int i = 0; i < 4; i++) rd(32'h0000_0300 + 32'(4 * i), "R4");
        // R2 back-to-back hits across lines
        rd(32'h0000_0104, "R2");
        rd(32'h0000_0208, "R2");
        rd(32'h0000_030C, "R2");
        rd(32'h0000_0100, "R2");
        idle(2);
        // R8 0x400 apart: separate lines, both stay
        rd(32'h0000_0504, "R8");
        rd(32'h0000_0104, "R8");
        rd(32'h0000_0504, "R8");
        // R7 0x800 apart: conflict evicts
        rd(32'h0000_0904, "R7");
        rd(32'h0000_0104, "R7");
        rd(32'h0000_0900, "R7");
        rd(32'h0000_0100, "R7");
        // R3 distant tag with varied request delay
        rd(32'h8000_1234, "R3");
        rd(32'h8000_1230, "R3");
        rd(32'h8000_1238, "R3");
        idle(6);
        check(miss_pending == 0, "R3", "outstanding miss at end", {31'b0, miss_pending}, 32'h0);
        check(exp_data.size() == 0, "R6", "missing responses", exp_data.size(), 32'h0);
        done = 1;
        summary();
    end
endmodule